// File: doc/BRIEF.md
# Event Channel Generator Router

This block holds a bank of six event channels. Each channel owns one byte-wide select register on a small register bus. The select code picks one peripheral event source and routes it onto that channel's raw event output. Software writes a code to route a source and writes zero to switch the channel off.

The meaning of a code depends on which channel it is written to. The periodic-timer tap codes pick a slower group of taps on even channels and a faster group on odd channels. The port-pin codes pick a different port for each channel pair. A port-pin event is forced to zero while that pin's input driver is disabled. Any code that is not in the routing set turns the channel off.

Every channel also has a second output for synchronous users. An asynchronous source reaches that output through two flops clocked by the system clock. A synchronous source reaches it directly.

Top module: `evt_chan_router`

## Requirements
- R1: After reset every select register reads 0x00 and every `evt_o` and `evt_sync_o` bit is low.
- R2: The select register of channel n sits at address 0x10+n (n = 0..5). A write with `we_i` high takes effect at the clock edge. `rdata_o` shows the register at `addr_i` one rising edge after the address is presented. Any other address reads 0x00, and a write to it changes no register.
- R3: Code 0x00 drives a channel's output low. Every code outside the set listed in R4, R5 and R7 also drives it low.
- R4: `pit_tap_i` bit k carries the prescaler tap divided by 2^(k+6). On even channels, codes 0x08, 0x09, 0x0A and 0x0B select bits 7, 6, 5 and 4. On odd channels the same codes select bits 3, 2, 1 and 0.
- R5: Codes 0x40+p select pin p. On channels 0-1 the pin comes from port A, on channels 2-3 from port C, and on channels 4-5 from port B. Codes 0x48+p select pin p of port B on channels 0-1, port A on channels 2-3 and port C on channels 4-5.
- R6: A selected port pin reads as zero while its bit in the matching `px_en_i` is low.
- R7: The following codes route the same source on every channel:
  - 0x01 `sync_char_i`
  - 0x06 `rtc_ovf_i`
  - 0x07 `rtc_cmp_i`
  - 0x10+i `lut_i[i]` (i = 0..3)
  - 0x20 `ac_i`
  - 0x24+i `adc_i[i]` (i = 0..2)
  - 0x60+i `usart_xck_i[i]` (i = 0..1)
  - 0x68 `spi_sck_i`
  - 0x80 `tca_i[0]`
  - 0x81 `tca_i[1]`
  - 0x84+i `tca_i[2+i]` (i = 0..2)
  - 0xA0+i `tcb_i[i]` (i = 0..3)
- R8: RTC, periodic-tap, LUT, comparator and port sources are asynchronous. For these sources `evt_sync_o` follows `evt_o` two rising clock edges later. For all other sources `evt_sync_o` equals `evt_o` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| sync_char_i | input | 1 | Sync-character rising edge event |
| rtc_ovf_i | input | 1 | RTC counter overflow |
| rtc_cmp_i | input | 1 | RTC compare match |
| pit_tap_i | input | 8 | Prescaler taps, bit k = divide by 2^(k+6) |
| lut_i | input | 4 | LUT output levels |
| ac_i | input | 1 | Comparator output level |
| adc_i | input | 3 | ADC result ready, sample ready, window compare |
| usart_xck_i | input | 2 | USART host clocks |
| spi_sck_i | input | 1 | SPI host clock |
| tca_i | input | 5 | Timer A events for codes 0x80, 0x81, 0x84..0x86 |
| tcb_i | input | 4 | Timer B capture/overflow, two instances |
| pa_i | input | 8 | Port A pin levels |
| pb_i | input | 8 | Port B pin levels |
| pc_i | input | 8 | Port C pin levels |
| pa_en_i | input | 8 | Port A input-driver enables |
| pb_en_i | input | 8 | Port B input-driver enables |
| pc_en_i | input | 8 | Port C input-driver enables |
| evt_o | output | 6 | Raw channel events |
| evt_sync_o | output | 6 | Channel events for synchronous users |

## Verification
The assertions check four things on every cycle:
- A zero or unlisted code keeps both outputs of its channel low.
- Any port-pin code yields zero when every driver enable is off.
- A written register holds the written byte one cycle later.
- A rising synchronised output on an asynchronous route matches the raw output of two cycles earlier.

The channel-dependent mapping can only be shown by the bench scenarios. These cover the tap order on even and odd channels, the port chosen per channel pair, the per-pin gating and the same-cycle bypass of synchronous sources. The bench sweeps every code on every channel against random source patterns for this.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int SEL_W = 8;
  localparam int PIN_N = 8;
  localparam int N_PORT = 3;

  typedef struct packed {
    logic             sync_char;
    logic             rtc_ovf;
    logic             rtc_cmp;
    logic [7:0]       pit_tap;
    logic [3:0]       lut;
    logic             ac;
    logic [2:0]       adc;
    logic [1:0]       usart_xck;
    logic             spi_sck;
    logic [4:0]       tca;
    logic [3:0]       tcb;
    logic [N_PORT-1:0][PIN_N-1:0] pin;
    logic [N_PORT-1:0][PIN_N-1:0] pin_en;
  } evt_src_t;

  // port index: 0 = A, 1 = B, 2 = C
  function automatic int lo_port(input int grp);
    case (grp)
      0: lo_port = 0;
      1: lo_port = 2;
      default: lo_port = 1;
    endcase
  endfunction

  function automatic int hi_port(input int grp);
    case (grp)
      0: hi_port = 1;
      1: hi_port = 0;
      default: hi_port = 2;
    endcase
  endfunction

  function automatic logic code_listed(input logic [SEL_W-1:0] c);
    code_listed = (c == 8'h01) || (c == 8'h06) || (c == 8'h07) ||
                  (c >= 8'h08 && c <= 8'h0B) || (c >= 8'h10 && c <= 8'h13) ||
                  (c == 8'h20) || (c >= 8'h24 && c <= 8'h26) ||
                  (c >= 8'h40 && c <= 8'h4F) || (c == 8'h60) || (c == 8'h61) ||
                  (c == 8'h68) || (c == 8'h80) || (c == 8'h81) ||
                  (c >= 8'h84 && c <= 8'h86) || (c >= 8'hA0 && c <= 8'hA3);
  endfunction
endpackage

// File: rtl/evt_regs.sv
module evt_regs #(
  parameter int N_CH   = 6,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] BASE = 8'h10
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  output logic [DATA_W-1:0]              rdata_o,
  output logic [N_CH-1:0][DATA_W-1:0]    sel_o
);
  logic [N_CH-1:0][DATA_W-1:0] regs_q;
  logic [DATA_W-1:0]           rd_mux;
  logic [DATA_W-1:0]           rdata_q;

  for (genvar k = 0; k < N_CH; k++) begin : g_reg
    localparam logic [ADDR_W-1:0] ADDR_K = BASE + ADDR_W'(k);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       regs_q[k] <= '0;
      else if (we_i && addr_i == ADDR_K) regs_q[k] <= wdata_i;
    end

    assert_wr_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == ADDR_K) |=> (sel_o[k] == $past(wdata_i)));
  end

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < N_CH; k++)
      if (addr_i == BASE + ADDR_W'(k)) rd_mux = regs_q[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
  assign sel_o   = regs_q;
endmodule

// File: rtl/evt_chan_decode.sv
module evt_chan_decode
  import evt_pkg::*;
#(
  parameter int CH = 0
) (
  input  logic [SEL_W-1:0] sel_i,
  input  evt_src_t         src_i,
  output logic             evt_o,
  output logic             async_o
);
  localparam bit ODD   = (CH % 2) == 1;
  localparam int GRP   = (CH / 2) % 3;
  localparam int LO_P  = lo_port(GRP);
  localparam int HI_P  = hi_port(GRP);
  localparam int TAP_T = ODD ? 3 : 7;   // top tap index for code 0x08

  logic [2:0] pin;
  int         tap;
  int         prt;

  always_comb begin
    evt_o   = 1'b0;
    async_o = 1'b0;
    pin     = sel_i[2:0];
    tap     = TAP_T - int'(sel_i[1:0]);
    prt     = sel_i[3] ? HI_P : LO_P;
    case (sel_i) inside
      8'h01:         evt_o = src_i.sync_char;
      8'h06:         begin evt_o = src_i.rtc_ovf; async_o = 1'b1; end
      8'h07:         begin evt_o = src_i.rtc_cmp; async_o = 1'b1; end
      [8'h08:8'h0B]: begin evt_o = src_i.pit_tap[tap]; async_o = 1'b1; end
      [8'h10:8'h13]: begin evt_o = src_i.lut[sel_i[1:0]]; async_o = 1'b1; end
      8'h20:         begin evt_o = src_i.ac; async_o = 1'b1; end
      [8'h24:8'h26]: evt_o = src_i.adc[sel_i[1:0]];
      [8'h40:8'h4F]: begin
        evt_o   = src_i.pin[prt][pin] & src_i.pin_en[prt][pin];
        async_o = 1'b1;
      end
      8'h60, 8'h61:  evt_o = src_i.usart_xck[sel_i[0]];
      8'h68:         evt_o = src_i.spi_sck;
      8'h80:         evt_o = src_i.tca[0];
      8'h81:         evt_o = src_i.tca[1];
      [8'h84:8'h86]: evt_o = src_i.tca[2 + int'(sel_i[1:0])];
      [8'hA0:8'hA3]: evt_o = src_i.tcb[sel_i[1:0]];
      default:       ;
    endcase
  end
endmodule

// File: rtl/evt_sync.sv
module evt_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  input  logic async_i,
  output logic sync_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= raw_i;
      s2_q <= s1_q;
    end
  end

  assign sync_o = async_i ? s2_q : raw_i;
endmodule

// File: rtl/evt_chan_router.sv
module evt_chan_router
  import evt_pkg::*;
#(
  parameter int N_CH   = 6,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE = 8'h10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SEL_W-1:0]  wdata_i,
  output logic [SEL_W-1:0]  rdata_o,
  input  logic              sync_char_i,
  input  logic              rtc_ovf_i,
  input  logic              rtc_cmp_i,
  input  logic [7:0]        pit_tap_i,
  input  logic [3:0]        lut_i,
  input  logic              ac_i,
  input  logic [2:0]        adc_i,
  input  logic [1:0]        usart_xck_i,
  input  logic              spi_sck_i,
  input  logic [4:0]        tca_i,
  input  logic [3:0]        tcb_i,
  input  logic [PIN_N-1:0]  pa_i,
  input  logic [PIN_N-1:0]  pb_i,
  input  logic [PIN_N-1:0]  pc_i,
  input  logic [PIN_N-1:0]  pa_en_i,
  input  logic [PIN_N-1:0]  pb_en_i,
  input  logic [PIN_N-1:0]  pc_en_i,
  output logic [N_CH-1:0]   evt_o,
  output logic [N_CH-1:0]   evt_sync_o
);
  logic [N_CH-1:0][SEL_W-1:0] sel;
  logic [N_CH-1:0]            async_w;
  evt_src_t                   src;

  always_comb begin
    src.sync_char = sync_char_i;
    src.rtc_ovf   = rtc_ovf_i;
    src.rtc_cmp   = rtc_cmp_i;
    src.pit_tap   = pit_tap_i;
    src.lut       = lut_i;
    src.ac        = ac_i;
    src.adc       = adc_i;
    src.usart_xck = usart_xck_i;
    src.spi_sck   = spi_sck_i;
    src.tca       = tca_i;
    src.tcb       = tcb_i;
    src.pin       = {pc_i, pb_i, pa_i};
    src.pin_en    = {pc_en_i, pb_en_i, pa_en_i};
  end

  evt_regs #(.N_CH(N_CH), .ADDR_W(ADDR_W), .DATA_W(SEL_W), .BASE(BASE)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .rdata_o, .sel_o(sel)
  );

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    evt_chan_decode #(.CH(k)) u_dec (
      .sel_i(sel[k]), .src_i(src), .evt_o(evt_o[k]), .async_o(async_w[k])
    );
    evt_sync u_sync (
      .clk_i, .rst_ni, .raw_i(evt_o[k]), .async_i(async_w[k]), .sync_o(evt_sync_o[k])
    );

    assert_chan_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel[k] == '0) |-> (!evt_o[k] && !evt_sync_o[k]));
    assert_unlisted_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !code_listed(sel[k]) |-> !evt_o[k]);
    assert_port_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel[k][7:4] == 4'h4 && pa_en_i == '0 && pb_en_i == '0 && pc_en_i == '0)
      |-> !evt_o[k]);
    assert_sync_lag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (async_w[k] && $rose(evt_sync_o[k])) |-> $past(evt_o[k], 2));
  end
endmodule

// File: tb/sim_evt_chan_router.sv
`timescale 1ns/1ps
module sim_evt_chan_router;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       we = 1'b0;
  logic [7:0] addr = '0, wdata = '0, rdata;
  logic       sync_char = 0, rtc_ovf = 0, rtc_cmp = 0, ac = 0, spi_sck = 0;
  logic [7:0] pit_tap = '0;
  logic [3:0] lut = '0, tcb = '0;
  logic [2:0] adc = '0;
  logic [1:0] usart = '0;
  logic [4:0] tca = '0;
  logic [7:0] pa = '0, pb = '0, pc = '0, pa_en = '0, pb_en = '0, pc_en = '0;
  logic [5:0] evt, evt_sync;

  evt_chan_router u0 (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .sync_char_i(sync_char), .rtc_ovf_i(rtc_ovf),
    .rtc_cmp_i(rtc_cmp), .pit_tap_i(pit_tap), .lut_i(lut), .ac_i(ac),
    .adc_i(adc), .usart_xck_i(usart), .spi_sck_i(spi_sck), .tca_i(tca),
    .tcb_i(tcb), .pa_i(pa), .pb_i(pb), .pc_i(pc), .pa_en_i(pa_en),
    .pb_en_i(pb_en), .pc_en_i(pc_en), .evt_o(evt), .evt_sync_o(evt_sync)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct { int ch; logic [7:0] code; logic exp; string tag; } item_t;
  item_t q[$];

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic pin_of(input int port, input int p);
    logic [7:0] v, e;
    if (port == 0) begin v = pa; e = pa_en; end
    else if (port == 1) begin v = pb; e = pb_en; end
    else begin v = pc; e = pc_en; end
    return v[p] & e[p];
  endfunction

  // independent reference decode from the requirements
  function automatic logic ref_evt(input int ch, input logic [7:0] c);
    int n = int'(c);
    int pair = ch / 2;
    if (n == 1) return sync_char;
    if (n == 6) return rtc_ovf;
    if (n == 7) return rtc_cmp;
    if (n >= 8 && n <= 11) return (ch % 2 == 0) ? pit_tap[15 - n] : pit_tap[11 - n];
    if (n >= 16 && n <= 19) return lut[n - 16];
    if (n == 32) return ac;
    if (n >= 36 && n <= 38) return adc[n - 36];
    if (n >= 64 && n <= 71)
      return pin_of(pair == 0 ? 0 : (pair == 1 ? 2 : 1), n - 64);
    if (n >= 72 && n <= 79)
      return pin_of(pair == 0 ? 1 : (pair == 1 ? 0 : 2), n - 72);
    if (n == 96 || n == 97) return usart[n - 96];
    if (n == 104) return spi_sck;
    if (n == 128) return tca[0];
    if (n == 129) return tca[1];
    if (n >= 132 && n <= 134) return tca[n - 130];
    if (n >= 160 && n <= 163) return tcb[n - 160];
    return 1'b0;
  endfunction

  function automatic string tag_of(input logic [7:0] c);
    if (c >= 8'h08 && c <= 8'h0B) return "R4";
    if (c >= 8'h40 && c <= 8'h4F) return "R5/R6";
    if (ref_listed(c)) return "R7";
    return "R3";
  endfunction

  function automatic bit ref_listed(input logic [7:0] c);
    int n = int'(c);
    return n == 1 || n == 6 || n == 7 || (n >= 16 && n <= 19) || n == 32 ||
           (n >= 36 && n <= 38) || n == 96 || n == 97 || n == 104 ||
           n == 128 || n == 129 || (n >= 132 && n <= 134) || (n >= 160 && n <= 163);
  endfunction

  task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic reg_read_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); we = 1'b0; addr = a;
    @(posedge clk); #2;
    chk(tag, rdata, exp);
  endtask

  task automatic randomize_src();
    sync_char = 1'($urandom); rtc_ovf = 1'($urandom); rtc_cmp = 1'($urandom);
    pit_tap = 8'($urandom); lut = 4'($urandom); ac = 1'($urandom);
    adc = 3'($urandom); usart = 2'($urandom); spi_sck = 1'($urandom);
    tca = 5'($urandom); tcb = 4'($urandom);
    pa = 8'($urandom); pb = 8'($urandom); pc = 8'($urandom);
    pa_en = 8'($urandom); pb_en = 8'($urandom); pc_en = 8'($urandom);
  endtask

  task automatic all_src(input logic v);
    sync_char = v; rtc_ovf = v; rtc_cmp = v; pit_tap = {8{v}}; lut = {4{v}};
    ac = v; adc = {3{v}}; usart = {2{v}}; spi_sck = v; tca = {5{v}}; tcb = {4{v}};
    pa = {8{v}}; pb = {8{v}}; pc = {8{v}};
    pa_en = 8'hFF; pb_en = 8'hFF; pc_en = 8'hFF;
  endtask

  task automatic push(input int ch, input logic [7:0] c);
    item_t it;
    it.ch = ch; it.code = c; it.exp = ref_evt(ch, c); it.tag = tag_of(c);
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  // monitor: pops expectations and compares the raw channel output
  initial begin
    item_t it;
    forever begin
      wait (q.size() != 0);
      #2;
      it = q[0];
      chk($sformatf("%s ch%0d code %h", it.tag, it.ch, it.code), 8'(evt[it.ch]), 8'(it.exp));
      void'(q.pop_front());
    end
  end

  initial begin
    #4_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    all_src(1'b1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    #2;
    chk("R1 evt", 8'(evt), 8'h00);
    chk("R1 evt_sync", 8'(evt_sync), 8'h00);
    for (int k = 0; k < 6; k++) reg_read_chk(8'h10 + 8'(k), 8'h00, "R1 reg");

    // R2 write/readback and unmapped addresses
    for (int k = 0; k < 6; k++) reg_write(8'h10 + 8'(k), 8'h5A ^ 8'(k * 17));
    reg_write(8'h16, 8'hFF);
    reg_write(8'h0F, 8'hFF);
    for (int k = 0; k < 6; k++) reg_read_chk(8'h10 + 8'(k), 8'h5A ^ 8'(k * 17), "R2 readback");
    reg_read_chk(8'h16, 8'h00, "R2 unmapped 0x16");
    reg_read_chk(8'h0F, 8'h00, "R2 unmapped 0x0F");

    // R3-R7 sweep: every code on every channel
    for (int ch = 0; ch < 6; ch++) begin
      for (int c = 0; c < 256; c++) begin
        reg_write(8'h10 + 8'(ch), 8'(c));
        @(negedge clk); all_src(1'b1); push(ch, 8'(c));
        @(negedge clk); all_src(1'b0); push(ch, 8'(c));
        for (int r = 0; r < 2; r++) begin
          @(negedge clk); randomize_src(); push(ch, 8'(c));
        end
      end
    end

    // R4 distinct taps: single hot tap on even vs odd channel
    reg_write(8'h10, 8'h09); reg_write(8'h11, 8'h09);
    @(negedge clk); all_src(1'b0); pit_tap = 8'h40; #2;
    chk("R4 even 0x09 tap6", 8'(evt[0]), 8'h01);
    chk("R4 odd 0x09 ignores tap6", 8'(evt[1]), 8'h00);
    @(negedge clk); pit_tap = 8'h04; #2;
    chk("R4 odd 0x09 tap2", 8'(evt[1]), 8'h01);

    // R6 pin gated by its own enable only
    reg_write(8'h12, 8'h43);
    @(negedge clk); all_src(1'b1); pc_en = 8'hF7; #2;
    chk("R6 gated pin", 8'(evt[2]), 8'h00);
    @(negedge clk); pc_en = 8'h08; pc = 8'h08; #2;
    chk("R6 enabled pin", 8'(evt[2]), 8'h01);

    // R8 async lag through two flops
    reg_write(8'h10, 8'h40);
    @(negedge clk); all_src(1'b0);
    repeat (3) @(negedge clk);
    pa[0] = 1'b1; #2;
    chk("R8 raw now", 8'(evt[0]), 8'h01);
    chk("R8 sync not yet", 8'(evt_sync[0]), 8'h00);
    @(posedge clk); #2;
    chk("R8 sync after 1 edge", 8'(evt_sync[0]), 8'h00);
    @(posedge clk); #2;
    chk("R8 sync after 2 edges", 8'(evt_sync[0]), 8'h01);

    // R8 synchronous source bypass
    reg_write(8'h13, 8'h01);
    @(negedge clk); all_src(1'b0);
    repeat (3) @(negedge clk);
    sync_char = 1'b1; #2;
    chk("R8 bypass same cycle", 8'(evt_sync[3]), 8'h01);

    // R3 off clears both outputs
    reg_write(8'h13, 8'h00); #2;
    chk("R3 off sync", 8'(evt_sync[3]), 8'h00);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule